// File: doc/BRIEF.md
# Synchronous dual-port byte-lane RAM

A true dual-port synchronous memory of 16-bit words split into two 8-bit byte lanes. Each side (left and right) has its own clock and reset, its own address, write data, read/write select, per-lane enables, a pair of opposite-polarity selects, an asynchronous output enable and an output-mode input. Both sides can reach any word at any time, including the same word on the same edge. A side reads only when both of its selects are active. On a write it changes only the lanes that are enabled.

Each side picks its read latency with its mode input. In flow-through mode the read data follows the sampling edge. In pipelined mode one more register stage sits on the data path. In pipelined mode the port selects also pass through two register stages, while the lane enables pass through one stage in both modes. Tri-state pads are replaced by a per-lane valid flag. A lane's data bits read zero whenever that lane's flag is low.

Depth is `2**ADDR_W` words. The default is 1024 words. Setting `ADDR_W` to 15 gives 32K words.

Top module: `dpram_dual`

## Requirements
- R1: A side counts as selected only when `*_sel_n` is 0 and `*_sel` is 1 at the clock edge. An edge where it is not selected writes nothing and produces no read data (valid flags 00).
- R2: With the side selected and `*_read` = 0, the edge writes the upper lane (bits 15..8) when `*_lane_n[1]` is 0 and the lower lane (bits 7..0) when `*_lane_n[0]` is 0. With `*_lane_n` = 11 nothing is written.
- R3: For read data, `*_vld[1]` marks the upper lane and `*_vld[0]` the lower lane. Only lanes enabled with a 0 in `*_lane_n` are flagged. The data bits of an unflagged lane read 0.
- R4: While `*_oe_n` is 1 the valid flags and the data are 0 at once, without waiting for a clock edge. When it returns to 0 the previous output reappears.
- R5: With `*_pipe` = 0, a read sampled at edge k shows its data and flags in the cycle after edge k. A write edge produces no flags.
- R6: With `*_pipe` = 1, the same read shows in the cycle after edge k+1, one cycle later than in R5.
- R7: A deselect at edge k clears the flags after edge k in flow-through mode and after edge k+1 in pipelined mode.
- R8: The lane enables are registered once in both modes. In pipelined mode the flags after edge k+1 follow `*_lane_n` sampled at edge k+1, not at edge k.
- R9: Both sides can read and write any address, including the same address together and the top address `2**ADDR_W-1`. Each side sees the data last written by either side.
- R10: When one side writes a word and the other side reads it on the same edge, the reader gets the contents from before the write.
- R11: When both sides write the same word on the same edge, the left side's data is stored in every lane that both sides write. A lane written by only one side takes that side's data.
- R12: A synchronous active-low reset (`*_rst_n`) clears that side's valid flags and data outputs. It leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| l_clk | input | 1 | Left side clock |
| l_rst_n | input | 1 | Left side synchronous reset, active low |
| l_sel_n | input | 1 | Left select, active low |
| l_sel | input | 1 | Left select, active high |
| l_read | input | 1 | Left direction: 1 read, 0 write |
| l_lane_n | input | 2 | Left lane enables, active low; bit 1 upper, bit 0 lower |
| l_oe_n | input | 1 | Left output enable, active low, asynchronous |
| l_pipe | input | 1 | Left mode: 1 pipelined, 0 flow-through |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | 16 | Left write data |
| l_dout | output | 16 | Left read data, zero on unflagged lanes |
| l_vld | output | 2 | Left per-lane output valid |
| r_clk | input | 1 | Right side clock |
| r_rst_n | input | 1 | Right side synchronous reset, active low |
| r_sel_n | input | 1 | Right select, active low |
| r_sel | input | 1 | Right select, active high |
| r_read | input | 1 | Right direction: 1 read, 0 write |
| r_lane_n | input | 2 | Right lane enables, active low; bit 1 upper, bit 0 lower |
| r_oe_n | input | 1 | Right output enable, active low, asynchronous |
| r_pipe | input | 1 | Right mode: 1 pipelined, 0 flow-through |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | 16 | Right write data |
| r_dout | output | 16 | Right read data, zero on unflagged lanes |
| r_vld | output | 2 | Right per-lane output valid |

## Verification
A corrupted storage bank or a wrong collision rule shows up as a wrong word on the next read of that address. That read gives data one cycle after its edge in flow-through mode and two cycles after in pipelined mode. A wrong select or lane pipeline stage shows up as flags that appear, linger or vanish one cycle off. This is visible on the first deselect or lane change after a read. A mix-up of the two lanes shows up on the first single-lane write that is read back.

// File: rtl/dpram_pkg.sv
// Package: shared geometry of the dual-port byte-lane RAM.
// Assumes a word is built from LANES equal byte lanes, lane 0 least significant.
package dpram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dpram_port.sv
// Module: per-side control and output stage.
// Decodes the selects into lane write enables and a read strobe. Holds the
// select/read history (one stage used in flow-through, two in pipelined), the
// single lane-enable stage and the extra read-data stage. Gates the outputs
// with the asynchronous output enable.
// Assumes rdata is a register loaded by the array on the same clock edge as rd_en.
module dpram_port
    import dpram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       sel,
    input  logic       read,
    input  lane_mask_t lane_n,
    input  logic       oe_n,
    input  logic       pipe,
    input  word_t      rdata,
    output lane_mask_t we,
    output logic       rd_en,
    output lane_mask_t vld,
    output word_t      dout
);
    logic       act_q1;
    logic       act_q2;
    lane_mask_t lane_n_q;
    word_t      rdata_q;
    logic       act_sel;
    word_t      data_sel;
    logic       selected;

    // Port decode: both selects must be active
    assign selected = ~sel_n & sel;
    assign rd_en    = selected & read;

    // Lane write strobes from the active-low lane enables
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            we[i] = selected & ~read & ~lane_n[i];
        end
    end

    // History registers: read strobe twice, lane enables once, data once more
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q1   <= 1'b0;
            act_q2   <= 1'b0;
            lane_n_q <= '1;
            rdata_q  <= '0;
        end else begin
            act_q1   <= rd_en;
            act_q2   <= act_q1;
            lane_n_q <= lane_n;
            rdata_q  <= rdata;
        end
    end

    // Mode select: pick the select history depth and data stage
    assign act_sel  = pipe ? act_q2 : act_q1;
    assign data_sel = pipe ? rdata_q : rdata;

    // Output gating per lane, output enable acts without a clock
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign vld[g] = act_sel & ~oe_n & ~lane_n_q[g];
            assign dout[g*LANE_W +: LANE_W] = vld[g] ? data_sel[g*LANE_W +: LANE_W]
                                                     : '0;
        end
    endgenerate
endmodule

// File: rtl/dpram_array.sv
// Module: two-clock storage with byte-lane writes.
// Each lane is stored as two banks, one written only by the left clock and one
// only by the right clock. A word is the XOR of both banks. A write stores its
// data XOR the other bank's current content. A read of the word being written
// on the same edge returns the old value. On a same-edge write to the same word
// and lane, the right write is dropped so the left data lands.
// Assumes same-edge collisions are only meaningful when both clocks are one net.
module dpram_array
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              l_clk,
    input  logic              l_rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  lane_mask_t        l_we,
    input  word_t             l_wdata,
    input  logic              l_rd_en,
    output word_t             l_rdata,
    input  logic              r_clk,
    input  logic              r_rst_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  lane_mask_t        r_we,
    input  word_t             r_wdata,
    input  logic              r_rd_en,
    output word_t             r_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic same_addr;
    assign same_addr = (l_addr == r_addr);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] bank_l [DEPTH];
            logic [LANE_W-1:0] bank_r [DEPTH];
            logic [LANE_W-1:0] l_rd_q;
            logic [LANE_W-1:0] r_rd_q;
            logic              r_we_eff;

            // Left priority on a same-word, same-lane collision
            assign r_we_eff = r_we[g] & ~(l_we[g] & same_addr);

            // Left bank update
            always_ff @(posedge l_clk) begin
                if (l_we[g]) begin
                    bank_l[l_addr] <= l_wdata[g*LANE_W +: LANE_W] ^ bank_r[l_addr];
                end
            end

            // Right bank update
            always_ff @(posedge r_clk) begin
                if (r_we_eff) begin
                    bank_r[r_addr] <= r_wdata[g*LANE_W +: LANE_W] ^ bank_l[r_addr];
                end
            end

            // Left read register, captures pre-edge contents
            always_ff @(posedge l_clk) begin
                if (!l_rst_n) begin
                    l_rd_q <= '0;
                end else if (l_rd_en) begin
                    l_rd_q <= bank_l[l_addr] ^ bank_r[l_addr];
                end
            end

            // Right read register, captures pre-edge contents
            always_ff @(posedge r_clk) begin
                if (!r_rst_n) begin
                    r_rd_q <= '0;
                end else if (r_rd_en) begin
                    r_rd_q <= bank_l[r_addr] ^ bank_r[r_addr];
                end
            end

            assign l_rdata[g*LANE_W +: LANE_W] = l_rd_q;
            assign r_rdata[g*LANE_W +: LANE_W] = r_rd_q;
        end
    endgenerate
endmodule

// File: rtl/dpram_dual.sv
// Module: top of the dual-port byte-lane RAM.
// Joins one control/output stage per side to the shared two-clock array.
// Assumes ADDR_W sets the depth; 15 gives 32K words.
module dpram_dual
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              l_clk,
    input  logic              l_rst_n,
    input  logic              l_sel_n,
    input  logic              l_sel,
    input  logic              l_read,
    input  logic [1:0]        l_lane_n,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [15:0]       l_din,
    output logic [15:0]       l_dout,
    output logic [1:0]        l_vld,
    input  logic              r_clk,
    input  logic              r_rst_n,
    input  logic              r_sel_n,
    input  logic              r_sel,
    input  logic              r_read,
    input  logic [1:0]        r_lane_n,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [15:0]       r_din,
    output logic [15:0]       r_dout,
    output logic [1:0]        r_vld
);
    lane_mask_t l_we, r_we;
    logic       l_rd_en, r_rd_en;
    word_t      l_rdata, r_rdata;

    dpram_port u_left (
        .clk(l_clk), .rst_n(l_rst_n), .sel_n(l_sel_n), .sel(l_sel),
        .read(l_read), .lane_n(l_lane_n), .oe_n(l_oe_n), .pipe(l_pipe),
        .rdata(l_rdata), .we(l_we), .rd_en(l_rd_en), .vld(l_vld), .dout(l_dout)
    );

    dpram_port u_right (
        .clk(r_clk), .rst_n(r_rst_n), .sel_n(r_sel_n), .sel(r_sel),
        .read(r_read), .lane_n(r_lane_n), .oe_n(r_oe_n), .pipe(r_pipe),
        .rdata(r_rdata), .we(r_we), .rd_en(r_rd_en), .vld(r_vld), .dout(r_dout)
    );

    dpram_array #(.ADDR_W(ADDR_W)) u_array (
        .l_clk(l_clk), .l_rst_n(l_rst_n), .l_addr(l_addr), .l_we(l_we),
        .l_wdata(l_din), .l_rd_en(l_rd_en), .l_rdata(l_rdata),
        .r_clk(r_clk), .r_rst_n(r_rst_n), .r_addr(r_addr), .r_we(r_we),
        .r_wdata(r_din), .r_rd_en(r_rd_en), .r_rdata(r_rdata)
    );
endmodule

// File: rtl/dpram_dual_chk.sv
// Module: port-level property checker for dpram_dual, attached by bind.
// Assumes the mode inputs change only away from the clock edges.
module dpram_dual_chk (
    input logic       l_clk,
    input logic       l_rst_n,
    input logic       l_sel_n,
    input logic       l_sel,
    input logic       l_read,
    input logic [1:0] l_lane_n,
    input logic       l_oe_n,
    input logic       l_pipe,
    input logic [1:0] l_vld,
    input logic       r_clk,
    input logic       r_rst_n,
    input logic       r_sel_n,
    input logic       r_sel,
    input logic       r_oe_n,
    input logic       r_pipe,
    input logic [1:0] r_vld
);
    // R4
    l_oe_quiet_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_oe_n |-> (l_vld == 2'b00));
    // R4
    r_oe_quiet_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        r_oe_n |-> (r_vld == 2'b00));
    // R5
    l_flow_src_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (!l_pipe && l_vld != 2'b00) |-> $past(l_read && !l_sel_n && l_sel));
    // R6
    l_pipe_src_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (l_pipe && l_vld != 2'b00) |-> $past(l_read && !l_sel_n && l_sel, 2));
    // R7
    l_flow_desel_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        (!l_pipe && $past(l_sel_n || !l_sel)) |-> (l_vld == 2'b00));
    // R7
    r_pipe_desel_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        (r_pipe && $past(r_sel_n || !r_sel) && $past(r_sel_n || !r_sel, 2))
        |-> (r_vld == 2'b00));
    // R8
    l_upper_once_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_vld[1] |-> !$past(l_lane_n[1]));
    // R8
    l_lower_once_chk: assert property (@(posedge l_clk) disable iff (!l_rst_n)
        l_vld[0] |-> !$past(l_lane_n[0]));
endmodule

bind dpram_dual dpram_dual_chk u_chk (
    .l_clk(l_clk), .l_rst_n(l_rst_n), .l_sel_n(l_sel_n), .l_sel(l_sel),
    .l_read(l_read), .l_lane_n(l_lane_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
    .l_vld(l_vld), .r_clk(r_clk), .r_rst_n(r_rst_n), .r_sel_n(r_sel_n),
    .r_sel(r_sel), .r_oe_n(r_oe_n), .r_pipe(r_pipe), .r_vld(r_vld)
);

// File: tb/dpram_dual_tb.sv
`timescale 1ns/1ps
module dpram_dual_tb;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n;
    logic l_sel_n, l_sel, l_read, l_oe_n, l_pipe;
    logic r_sel_n, r_sel, r_read, r_oe_n, r_pipe;
    logic [1:0] l_lane_n, r_lane_n, l_vld, r_vld;
    logic [AW-1:0] l_addr, r_addr;
    logic [15:0] l_din, r_din, l_dout, r_dout;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dpram_dual #(.ADDR_W(AW)) u_dut (
        .l_clk(clk), .l_rst_n(rst_n), .l_sel_n(l_sel_n), .l_sel(l_sel),
        .l_read(l_read), .l_lane_n(l_lane_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
        .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_vld(l_vld),
        .r_clk(clk), .r_rst_n(rst_n), .r_sel_n(r_sel_n), .r_sel(r_sel),
        .r_read(r_read), .r_lane_n(r_lane_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
        .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_vld(r_vld)
    );

    // Bench reference state for the random phase
    logic [15:0] mm [16];
    logic        m_act1 [2];
    logic        m_act2 [2];
    logic [15:0] m_d1 [2];
    logic [15:0] m_d2 [2];
    logic [1:0]  m_bs1 [2];
    int          l_idx, r_idx;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lset(input bit s, input bit rd, input logic [1:0] ln,
                        input int a, input logic [15:0] d);
        l_sel_n = !s; l_sel = s; l_read = rd; l_lane_n = ln;
        l_addr = a[AW-1:0]; l_din = d;
    endtask

    task automatic rset(input bit s, input bit rd, input logic [1:0] ln,
                        input int a, input logic [15:0] d);
        r_sel_n = !s; r_sel = s; r_read = rd; r_lane_n = ln;
        r_addr = a[AW-1:0]; r_din = d;
    endtask

    function automatic int map_addr(input int idx);
        return (idx == 15) ? DEPTH - 1 : idx;
    endfunction

    function automatic logic [1:0] exp_vld(input int p, input bit pipe, input bit oe_n);
        logic a;
        a = pipe ? m_act2[p] : m_act1[p];
        return (a && !oe_n) ? ~m_bs1[p] : 2'b00;
    endfunction

    function automatic logic [15:0] exp_dout(input int p, input bit pipe, input logic [1:0] v);
        logic [15:0] d;
        d = pipe ? m_d2[p] : m_d1[p];
        return {v[1] ? d[15:8] : 8'h00, v[0] ? d[7:0] : 8'h00};
    endfunction

    // Advance the reference by one edge using the inputs now applied
    task automatic model_edge();
        bit ls, rs;
        logic [15:0] lold, rold;
        ls = !l_sel_n && l_sel;
        rs = !r_sel_n && r_sel;
        lold = mm[l_idx];
        rold = mm[r_idx];
        m_d2[0] = m_d1[0]; m_act2[0] = m_act1[0];
        m_d2[1] = m_d1[1]; m_act2[1] = m_act1[1];
        if (ls && l_read) m_d1[0] = lold;
        if (rs && r_read) m_d1[1] = rold;
        m_act1[0] = ls && l_read;
        m_act1[1] = rs && r_read;
        m_bs1[0] = l_lane_n;
        m_bs1[1] = r_lane_n;
        // right first, then left, so the left side wins a shared lane
        if (rs && !r_read) begin
            if (!r_lane_n[1]) mm[r_idx][15:8] = r_din[15:8];
            if (!r_lane_n[0]) mm[r_idx][7:0]  = r_din[7:0];
        end
        if (ls && !l_read) begin
            if (!l_lane_n[1]) mm[l_idx][15:8] = l_din[15:8];
            if (!l_lane_n[0]) mm[l_idx][7:0]  = l_din[7:0];
        end
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0;
        lset(0, 1, 2'b00, 0, 16'h0); rset(0, 1, 2'b00, 0, 16'h0);
        l_oe_n = 0; r_oe_n = 0; l_pipe = 0; r_pipe = 0;
        @(negedge clk);
        tick(); tick(); tick();
        // R12 reset state
        check("R12 l_vld", {14'b0, l_vld}, 16'h0);
        check("R12 r_vld", {14'b0, r_vld}, 16'h0);
        check("R12 l_dout", l_dout, 16'h0);
        rst_n = 1'b1;

        // R5 flow-through write then read
        lset(1, 0, 2'b00, 3, 16'hA55A); tick();
        check("R5 no flags after write", {14'b0, l_vld}, 16'h0);
        lset(1, 1, 2'b00, 3, 16'h0); tick();
        check("R5 flow vld", {14'b0, l_vld}, 16'h3);
        check("R5 flow data", l_dout, 16'hA55A);

        // R2 upper-lane write, then write with no lanes
        lset(1, 0, 2'b01, 3, 16'h1234); tick();
        lset(1, 0, 2'b11, 3, 16'hFFFF); tick();
        lset(1, 1, 2'b00, 3, 16'h0); tick();
        check("R2 lane write", l_dout, 16'h125A);

        // R3 lower lane only
        lset(1, 1, 2'b10, 3, 16'h0); tick();
        check("R3 vld lower", {14'b0, l_vld}, 16'h1);
        check("R3 dout lower", l_dout, 16'h005A);

        // R4 asynchronous output enable
        l_oe_n = 1; #1;
        check("R4 oe vld", {14'b0, l_vld}, 16'h0);
        check("R4 oe dout", l_dout, 16'h0);
        l_oe_n = 0; #1;
        check("R4 oe release", {14'b0, l_vld}, 16'h1);

        // R1 / R7 flow-through deselect by either select
        l_sel_n = 0; l_sel = 0; l_lane_n = 2'b00; tick();
        check("R1 sel low vld", {14'b0, l_vld}, 16'h0);
        l_sel_n = 1; l_sel = 1; tick();
        check("R7 flow desel", {14'b0, l_vld}, 16'h0);
        l_read = 0; l_din = 16'h0000; tick();
        lset(1, 1, 2'b00, 3, 16'h0); tick();
        check("R1 no write when deselected", l_dout, 16'h125A);

        // R6 pipelined read latency on the right
        r_pipe = 1;
        rset(1, 1, 2'b00, 3, 16'h0); tick();
        check("R6 pipe not yet", {14'b0, r_vld}, 16'h0);
        tick();
        check("R6 pipe vld", {14'b0, r_vld}, 16'h3);
        check("R6 pipe data", r_dout, 16'h125A);

        // R7 pipelined deselect needs two edges
        r_sel = 0; tick();
        check("R7 pipe linger", {14'b0, r_vld}, 16'h3);
        tick();
        check("R7 pipe desel", {14'b0, r_vld}, 16'h0);

        // R8 lane enables sampled one edge after the read in pipelined mode
        rset(1, 1, 2'b00, 3, 16'h0); tick();
        r_sel = 0; r_lane_n = 2'b01; tick();
        check("R8 late lane vld", {14'b0, r_vld}, 16'h2);
        check("R8 late lane data", r_dout, 16'h1200);
        tick();
        check("R8 then empty", {14'b0, r_vld}, 16'h0);

        // R10 read-during-write returns old data
        r_pipe = 0;
        lset(1, 0, 2'b00, 5, 16'h7777); rset(0, 1, 2'b00, 5, 16'h0); tick();
        lset(1, 0, 2'b00, 5, 16'h8888); rset(1, 1, 2'b00, 5, 16'h0); tick();
        check("R10 old data", r_dout, 16'h7777);
        lset(0, 1, 2'b00, 5, 16'h0); tick();
        check("R9 cross-side write seen", r_dout, 16'h8888);
        lset(1, 1, 2'b00, 5, 16'h0); tick();
        check("R9 same addr left", l_dout, 16'h8888);
        check("R9 same addr right", r_dout, 16'h8888);

        // R11 same-edge write collision
        lset(1, 0, 2'b00, 6, 16'h1111); rset(1, 0, 2'b00, 6, 16'h2222); tick();
        lset(1, 1, 2'b00, 6, 16'h0); rset(0, 1, 2'b00, 0, 16'h0); tick();
        check("R11 left wins", l_dout, 16'h1111);
        lset(1, 0, 2'b10, 6, 16'h00AA); rset(1, 0, 2'b00, 6, 16'hBBCC); tick();
        lset(1, 1, 2'b00, 6, 16'h0); rset(0, 1, 2'b00, 0, 16'h0); tick();
        check("R11 per-lane merge", l_dout, 16'hBBAA);

        // Prepare random phase: empty pipelines, known contents at 16 addresses
        lset(0, 1, 2'b00, 0, 16'h0); tick(); tick();
        for (int i = 0; i < 16; i++) begin
            mm[i] = 16'h1000 + 16'(i * 16'h0111);
            lset(1, 0, 2'b00, map_addr(i), mm[i]); tick();
        end
        lset(0, 1, 2'b00, 0, 16'h0); tick(); tick();
        for (int p = 0; p < 2; p++) begin
            m_act1[p] = 0; m_act2[p] = 0; m_d1[p] = 0; m_d2[p] = 0; m_bs1[p] = 2'b11;
        end
        l_idx = 0; r_idx = 0;

        // R9 random traffic on both sides against the reference
        for (int c = 0; c < 4000; c++) begin
            logic [1:0] ev;
            if (c % 256 == 0) begin
                l_pipe = 1'($urandom % 2);
                r_pipe = 1'($urandom % 2);
            end
            l_idx = $urandom % 16; r_idx = $urandom % 16;
            l_sel_n = ($urandom % 8) == 0; l_sel = ($urandom % 8) != 0;
            r_sel_n = ($urandom % 8) == 0; r_sel = ($urandom % 8) != 0;
            l_read = 1'($urandom % 2); r_read = 1'($urandom % 2);
            l_lane_n = 2'($urandom); r_lane_n = 2'($urandom);
            l_oe_n = ($urandom % 8) == 0; r_oe_n = ($urandom % 8) == 0;
            l_addr = AW'(map_addr(l_idx)); r_addr = AW'(map_addr(r_idx));
            l_din = 16'($urandom); r_din = 16'($urandom);
            #1;
            ev = exp_vld(0, l_pipe, l_oe_n);
            check("R9 random l_vld", {14'b0, l_vld}, {14'b0, ev});
            check("R9 random l_dout", l_dout, exp_dout(0, l_pipe, ev));
            ev = exp_vld(1, r_pipe, r_oe_n);
            check("R9 random r_vld", {14'b0, r_vld}, {14'b0, ev});
            check("R9 random r_dout", r_dout, exp_dout(1, r_pipe, ev));
            model_edge();
            tick();
        end

        // R12 reset clears outputs but keeps contents
        lset(1, 1, 2'b00, 0, 16'h0); l_pipe = 0; l_oe_n = 0; tick();
        rst_n = 0; tick();
        check("R12 reset clears vld", {14'b0, l_vld}, 16'h0);
        rst_n = 1; tick();
        check("R12 contents kept", l_dout, mm[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule